// File: doc/BRIEF.md
# Multi-State Trigger Sequencer

This block is a programmable state machine that decides when a logic-analyser acquisition triggers. Every clock it receives a vector of term hits, which are the results of the comparators upstream. Each state reduces the terms it selects to three conditions: hit, else and capture. Each condition uses its own mask and its own logic function.

A hit condition advances a per-state occurrence counter. When the counter reaches the state's target, the state performs its programmed actions. These actions can set the trigger, advance to the following state, and start or stop any of the interval timers. An else condition that is true while hit is false moves the sequencer to a programmed state. The capture condition tells the memory which samples to store until the trigger fires. After that, every sample is stored.

A narrow write port loads the per-state configuration. An arm pulse starts a new acquisition from state 0.

Top module: `trig_seq`

## Requirements
- R1: After reset the block is idle: `state_o`=0, `armed_o`=0, `trig_o`=0, `capture_o`=0, and all timers are stopped at 0. Every configured condition op reads as 6 (never true).
- R2: A cycle with `arm`=1 sets `armed_o` and, at the same edge, clears the state to 0, the occurrence count, the trigger and all timers.
- R3: A condition applies its op to the terms chosen by its mask: 0=AND of selected, 1=NAND, 2=OR, 3=NOR, 4=XOR, 5=XNOR, 6=always false, 7=always true. An AND over an empty mask is true.
- R4: A full hit happens on the N-th cycle with the hit condition true in a state whose target is N; a target of 0 behaves as 1. The hit cycles need not be consecutive.
- R5: In a cycle where neither hit nor else is true, the state and the occurrence count are kept.
- R6: In a cycle where else is true and hit is false, the sequencer goes to the programmed else state.
- R7: When hit and else are both true, hit wins, even if that hit does not complete the count.
- R8: On a full hit, the advance action moves to state+1, wrapping from the last state to 0. The trigger action sets `trig_o`, which stays set until the next arm.
- R9: The occurrence count clears on every full hit and on every else move, so a state that is re-entered counts from zero.
- R10: `capture_o` is 0 while not armed. While armed it equals the capture condition until the trigger fires, and it is 1 from the cycle after the trigger fires.
- R11: A timer start action clears that timer and runs it, adding 1 per clock. A stop action holds its value. If one full hit both starts and stops the same timer, stop wins.
- R12: Configuration is written through `cfg_wdata` while `cfg_we`=1, into state `cfg_state`, with the field chosen by `cfg_sel`:
  - 0=hit, 1=else, 2=capture, each as mask in bits [NTERMS-1:0] and op in bits [22:20];
  - 3=target in bits [19:0];
  - 4=actions, as else state in [3:0], trigger in bit 8, advance in bit 9, timer starts from bit 10, and timer stops from bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Starts an acquisition from state 0 |
| term_hits | input | NTERMS | Term hit vector for this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_state | input | SW | State written |
| cfg_sel | input | 3 | Field written |
| cfg_wdata | input | CNT_W+3 | Field value |
| state_o | output | SW | Current state |
| armed_o | output | 1 | Acquisition in progress |
| trig_o | output | 1 | Trigger has fired |
| capture_o | output | 1 | Store this cycle's sample |
| timer_run_o | output | NTIMERS | Timer running flags |
| timer_val_o | output | NTIMERS*TMR_W | Timer values, timer 0 in the low bits |

## Verification
The assertions check the following on every cycle:
- an idle cycle changes neither the state nor the count;
- a partial hit adds exactly one to the count;
- every full hit or else move leaves the count at zero;
- the trigger stays set until the next arm;
- a stopped timer does not move.

Only the directed scenarios can show the values that arise from programmed content:
- the truth table of each op;
- the exact cycle on which a target is reached;
- that hit beats else;
- the wrap from the last state;
- the stop-over-start rule on timers;
- the switch of capture to unconditional after the trigger.

// File: rtl/trig_seq.sv
module trig_seq #(
  parameter int NTERMS  = 8,
  parameter int NSTATES = 16,
  parameter int CNT_W   = 20,
  parameter int NTIMERS = 2,
  parameter int TMR_W   = 36,
  localparam int SW     = $clog2(NSTATES),
  localparam int CW     = CNT_W + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     arm,
  input  logic [NTERMS-1:0]        term_hits,
  input  logic                     cfg_we,
  input  logic [SW-1:0]            cfg_state,
  input  logic [2:0]               cfg_sel,
  input  logic [CW-1:0]            cfg_wdata,
  output logic [SW-1:0]            state_o,
  output logic                     armed_o,
  output logic                     trig_o,
  output logic                     capture_o,
  output logic [NTIMERS-1:0]       timer_run_o,
  output logic [NTIMERS*TMR_W-1:0] timer_val_o
);
  localparam logic [2:0] OP_NEVER = 3'd6;
  localparam int ACT_TRIG  = 8;
  localparam int ACT_ADV   = 9;
  localparam int ACT_START = 10;
  localparam int ACT_STOP  = 14;

  logic [NTERMS-1:0]  m_hit  [NSTATES];
  logic [NTERMS-1:0]  m_else [NSTATES];
  logic [NTERMS-1:0]  m_cap  [NSTATES];
  logic [2:0]         o_hit  [NSTATES];
  logic [2:0]         o_else [NSTATES];
  logic [2:0]         o_cap  [NSTATES];
  logic [CNT_W-1:0]   tgt    [NSTATES];
  logic [SW-1:0]      es     [NSTATES];
  logic               a_trig [NSTATES];
  logic               a_adv  [NSTATES];
  logic [NTIMERS-1:0] a_start[NSTATES];
  logic [NTIMERS-1:0] a_stop [NSTATES];

  logic [SW-1:0]    st;
  logic [CNT_W-1:0] hcnt;
  logic             armed, trig;
  logic [NTIMERS-1:0] trun;
  logic [TMR_W-1:0]   tval [NTIMERS];

  function automatic logic eval(input logic [NTERMS-1:0] mask,
                                input logic [2:0] op,
                                input logic [NTERMS-1:0] t);
    logic all_s, any_s, par_s;
    all_s = &(t | ~mask);
    any_s = |(t & mask);
    par_s = ^(t & mask);
    case (op)
      3'd0: eval = all_s;
      3'd1: eval = ~all_s;
      3'd2: eval = any_s;
      3'd3: eval = ~any_s;
      3'd4: eval = par_s;
      3'd5: eval = ~par_s;
      3'd6: eval = 1'b0;
      default: eval = 1'b1;
    endcase
  endfunction

  logic hit_c, else_c, cap_c, full;
  logic [CNT_W-1:0] tgt_eff;
  logic [SW-1:0]    st_next;

  assign hit_c   = armed & eval(m_hit[st],  o_hit[st],  term_hits);
  assign else_c  = armed & eval(m_else[st], o_else[st], term_hits);
  assign cap_c   = eval(m_cap[st], o_cap[st], term_hits);
  assign tgt_eff = (tgt[st] == '0) ? CNT_W'(1) : tgt[st];
  assign full    = hit_c && ({1'b0, hcnt} + 1'b1 >= {1'b0, tgt_eff});
  assign st_next = (st == SW'(NSTATES-1)) ? '0 : st + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTATES; i++) begin
        m_hit[i] <= '0;  m_else[i] <= '0;  m_cap[i] <= '0;
        o_hit[i] <= OP_NEVER; o_else[i] <= OP_NEVER; o_cap[i] <= OP_NEVER;
        tgt[i] <= CNT_W'(1); es[i] <= '0;
        a_trig[i] <= 1'b0; a_adv[i] <= 1'b0;
        a_start[i] <= '0; a_stop[i] <= '0;
      end
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: begin m_hit[cfg_state]  <= cfg_wdata[NTERMS-1:0]; o_hit[cfg_state]  <= cfg_wdata[CW-1 -: 3]; end
        3'd1: begin m_else[cfg_state] <= cfg_wdata[NTERMS-1:0]; o_else[cfg_state] <= cfg_wdata[CW-1 -: 3]; end
        3'd2: begin m_cap[cfg_state]  <= cfg_wdata[NTERMS-1:0]; o_cap[cfg_state]  <= cfg_wdata[CW-1 -: 3]; end
        3'd3: tgt[cfg_state] <= cfg_wdata[CNT_W-1:0];
        3'd4: begin
          es[cfg_state]      <= cfg_wdata[SW-1:0];
          a_trig[cfg_state]  <= cfg_wdata[ACT_TRIG];
          a_adv[cfg_state]   <= cfg_wdata[ACT_ADV];
          a_start[cfg_state] <= cfg_wdata[ACT_START +: NTIMERS];
          a_stop[cfg_state]  <= cfg_wdata[ACT_STOP +: NTIMERS];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0; hcnt <= '0; armed <= 1'b0; trig <= 1'b0;
    end else if (arm) begin
      st <= '0; hcnt <= '0; armed <= 1'b1; trig <= 1'b0;
    end else if (hit_c) begin
      if (full) begin
        hcnt <= '0;
        if (a_adv[st])  st <= st_next;
        if (a_trig[st]) trig <= 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end else if (else_c) begin
      st   <= es[st];
      hcnt <= '0;
    end
  end

  for (genvar g = 0; g < NTIMERS; g++) begin : g_tmr
    always_ff @(posedge clk) begin
      if (!rst_n || arm) begin
        trun[g] <= 1'b0; tval[g] <= '0;
      end else if (full && a_stop[st][g]) begin
        trun[g] <= 1'b0;
      end else if (full && a_start[st][g]) begin
        trun[g] <= 1'b1; tval[g] <= '0;
      end else if (trun[g]) begin
        tval[g] <= tval[g] + 1'b1;
      end
    end
    assign timer_val_o[g*TMR_W +: TMR_W] = tval[g];

    assert_timer_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!trun[g] && !arm && !(full && a_start[st][g])) |=> $stable(tval[g]));
  end

  assign state_o     = st;
  assign armed_o     = armed;
  assign trig_o      = trig;
  assign timer_run_o = trun;
  assign capture_o   = armed & (trig | cap_c);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !arm && !hit_c && !else_c) |=> ($stable(st) && $stable(hcnt)));
  assert_partial_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && hit_c && !full) |=> (hcnt == $past(hcnt) + 1'b1 && $stable(st)));
  assert_count_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && (full || (!hit_c && else_c))) |=> (hcnt == '0));
  assert_trig_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !arm) |=> trig);
  assert_arm_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (armed && st == '0 && hcnt == '0 && !trig && trun == '0));
endmodule

// File: tb/tb_trig_seq.sv
module tb_trig_seq;
  localparam int NT = 8, NS = 16, CNW = 20, NTM = 2, TW = 36;
  localparam int SW = $clog2(NS), CW = CNW + 3;

  logic clk = 0, rst_n = 0, arm = 0, cfg_we = 0;
  logic [NT-1:0] term_hits = '0;
  logic [SW-1:0] cfg_state = '0;
  logic [2:0] cfg_sel = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [SW-1:0] state_o;
  logic armed_o, trig_o, capture_o;
  logic [NTM-1:0] timer_run_o;
  logic [NTM*TW-1:0] timer_val_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trig_seq dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [NT-1:0] t);
    term_hits = t;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cfg(input int s, input int sel, input logic [CW-1:0] d);
    cfg_we = 1; cfg_state = SW'(s); cfg_sel = 3'(sel); cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic logic [CW-1:0] cw(input logic [NT-1:0] m, input int op);
    return {3'(op), {(CW-3-NT){1'b0}}, m};
  endfunction

  function automatic logic [CW-1:0] aw(input int es, input bit tr, input bit adv,
                                       input logic [3:0] st, input logic [3:0] sp);
    logic [CW-1:0] w = '0;
    w[3:0] = 4'(es); w[8] = tr; w[9] = adv; w[13:10] = st; w[17:14] = sp;
    return w;
  endfunction

  task automatic do_reset();
    rst_n = 0; arm = 0; term_hits = '0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic do_arm();
    arm = 1; @(posedge clk); @(negedge clk); arm = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(state_o == 0, "R1 state", state_o, 0);
    chk(!armed_o && !trig_o && !capture_o, "R1 flags", {armed_o, trig_o, capture_o}, 0);
    chk(timer_val_o == 0 && timer_run_o == 0, "R1 timers", timer_val_o[35:0], 0);
    cfg(0, 2, cw('0, 7));
    step('1);
    chk(capture_o == 0, "R10 unarmed capture", capture_o, 0);
    do_arm();
    chk(armed_o && state_o == 0, "R2 armed", armed_o, 1);
  endtask

  task automatic t_ops();
    logic [NT-1:0] pats [4] = '{8'hF7, 8'hF5, 8'hF0, 8'h02};
    do_reset();
    do_arm();
    for (int op = 0; op < 8; op++) begin
      cfg(0, 2, cw(8'h07, op));
      for (int p = 0; p < 4; p++) begin
        logic [NT-1:0] s;
        logic e;
        s = pats[p] & 8'h07;
        case (op)
          0: e = (s == 8'h07);
          1: e = (s != 8'h07);
          2: e = |s;
          3: e = ~|s;
          4: e = ^s;
          5: e = ~^s;
          6: e = 0;
          default: e = 1;
        endcase
        term_hits = pats[p]; #1;
        chk(capture_o == e, $sformatf("R3 R12 op%0d pat%0d", op, p), capture_o, e);
      end
    end
    cfg(0, 2, cw('0, 0)); #1;
    chk(capture_o == 1, "R3 empty AND", capture_o, 1);
  endtask

  task automatic t_count();
    do_reset();
    cfg(0, 0, cw(8'h01, 2)); cfg(0, 3, 23'd3); cfg(0, 4, aw(0, 0, 1, 0, 0));
    do_arm();
    step(8'h01); step(8'h01);
    chk(state_o == 0, "R4 partial", state_o, 0);
    step(8'h00); step(8'h00);
    chk(state_o == 0, "R5 idle keeps", state_o, 0);
    step(8'h01);
    chk(state_o == 1, "R4 third hit advances", state_o, 1);
    cfg(1, 0, cw(8'h01, 2)); cfg(1, 3, 23'd0); cfg(1, 4, aw(0, 0, 1, 0, 0));
    step(8'h01);
    chk(state_o == 2, "R4 target zero as one", state_o, 2);
  endtask

  task automatic t_else();
    do_reset();
    cfg(0, 0, cw(8'h01, 2)); cfg(0, 3, 23'd3); cfg(0, 4, aw(5, 0, 1, 0, 0));
    cfg(0, 1, cw(8'h02, 2));
    cfg(5, 1, cw(8'h04, 2)); cfg(5, 4, aw(0, 0, 0, 0, 0));
    do_arm();
    step(8'h01); step(8'h01);
    step(8'h02);
    chk(state_o == 5, "R6 else jump", state_o, 5);
    step(8'h04);
    chk(state_o == 0, "R6 else back", state_o, 0);
    step(8'h01); step(8'h01);
    chk(state_o == 0, "R9 count restarted", state_o, 0);
    step(8'h01);
    chk(state_o == 1, "R9 full after three", state_o, 1);
  endtask

  task automatic t_priority();
    do_reset();
    cfg(0, 0, cw(8'h01, 2)); cfg(0, 1, cw(8'h01, 2)); cfg(0, 4, aw(9, 0, 1, 0, 0));
    cfg(1, 0, cw(8'h01, 2)); cfg(1, 1, cw(8'h01, 2)); cfg(1, 3, 23'd2);
    cfg(1, 4, aw(9, 0, 1, 0, 0));
    do_arm();
    step(8'h01);
    chk(state_o == 1, "R7 hit over else", state_o, 1);
    step(8'h01);
    chk(state_o == 1, "R7 partial hit over else", state_o, 1);
    step(8'h01);
    chk(state_o == 2, "R7 then full", state_o, 2);
  endtask

  task automatic t_trigger();
    do_reset();
    cfg(0, 0, cw(8'h01, 2)); cfg(0, 4, aw(0, 1, 0, 0, 0)); cfg(0, 2, cw('0, 6));
    do_arm();
    term_hits = 8'h00; #1;
    chk(capture_o == 0, "R10 pre-trigger gated", capture_o, 0);
    step(8'h01);
    chk(trig_o == 1 && state_o == 0, "R8 trigger set no advance", trig_o, 1);
    term_hits = 8'h00; #1;
    chk(capture_o == 1, "R10 capture after trigger", capture_o, 1);
    step(8'h00); step(8'h00);
    chk(trig_o == 1, "R8 trigger sticky", trig_o, 1);
    do_arm();
    chk(trig_o == 0, "R2 arm clears trigger", trig_o, 0);
  endtask

  task automatic t_wrap();
    do_reset();
    cfg(0, 1, cw(8'h02, 2)); cfg(0, 4, aw(15, 0, 0, 0, 0));
    cfg(15, 0, cw(8'h01, 2)); cfg(15, 4, aw(0, 0, 1, 0, 0));
    do_arm();
    step(8'h02);
    chk(state_o == 15, "R6 else to last", state_o, 15);
    step(8'h01);
    chk(state_o == 0, "R8 wrap to zero", state_o, 0);
  endtask

  task automatic t_timers();
    do_reset();
    cfg(0, 0, cw(8'h01, 2)); cfg(0, 4, aw(0, 0, 1, 4'b0001, 0));
    cfg(1, 0, cw(8'h01, 2)); cfg(1, 4, aw(0, 0, 1, 4'b0001, 4'b0001));
    do_arm();
    step(8'h01);
    chk(timer_run_o[0] && timer_val_o[35:0] == 0, "R11 start", timer_val_o[35:0], 0);
    for (int i = 0; i < 4; i++) step(8'h00);
    chk(timer_val_o[35:0] == 4, "R11 counting", timer_val_o[35:0], 4);
    step(8'h01);
    chk(!timer_run_o[0] && timer_val_o[35:0] == 4, "R11 stop wins", timer_val_o[35:0], 4);
    for (int i = 0; i < 3; i++) step(8'h00);
    chk(timer_val_o[35:0] == 4, "R11 held", timer_val_o[35:0], 4);
    chk(timer_val_o[71:36] == 0 && !timer_run_o[1], "R11 other timer idle", timer_val_o[71:36], 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset(); t_ops(); t_count(); t_else(); t_priority();
    t_trigger(); t_wrap(); t_timers();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule